// File: doc/BRIEF.md
# Four-Lane Serial Thermometer Bridge

This block is a memory-mapped slave through which a host bit-bangs a three-wire command and data protocol toward four temperature sensors at once. The host controls the serial clock level and a reset through a control register, pushes single bits through a data-write register, and pulls bits back through a data-read register. An eight-bit command is assembled least significant bit first; once a read command is held, every read returns one bit from each of the four lanes packed side by side, and all lanes step through their values together.

Each lane keeps a nine-bit temperature value (half-degree units) and an eight-bit configuration value. Both can be loaded from a side port so that a test environment or a system model can present any reading. There is no conversion logic: the lanes only serve what they hold.

Top module: `thermo_bridge`

## Requirements
- R1: After reset every lane's temperature value is 44 and every configuration value is 0x02, the clock-low flag is clear, the command and data shifters are empty, `bus_rdata` is 0 and `cmd_unknown` is 0.
- R2: Address 0 is the control register, address 1 the data-write register, address 2 the data-read register. Control value 0x01 resets the shifters, 0x02 sets the clock-low flag, 0x03 clears it; any other control value has no effect.
- R3: A control write of 0x01 clears the command value, command bit count, data value and data bit position; the clock-low flag keeps its value.
- R4: While the clock-low flag is clear, data writes of any value other than 0x04 change nothing.
- R5: A data write of 0x04 sets the data bit position to zero whether or not the clock-low flag is set, and changes nothing else.
- R6: While the command is incomplete and clock-low is set, each data write fills the next command bit, starting at bit 0; the value 0x01 makes that bit one, any other value leaves it zero. Eight writes complete the command.
- R7: A completed command 0xEE clears the shifters. A completed 0xAA (read temperature) or 0xAC (read configuration) is held. Any other completed command raises `cmd_unknown` for exactly the one cycle after the completing write.
- R8: With the command complete and clock-low set, each data write (other than 0x04) shifts one bit into the data value, LSB first, and advances the same bit position that reads use.
- R9: A read of address 2 under a held read command places the bit at the current position of lane i's selected value on `bus_rdata[i]`, visible from the cycle after the read and kept until the next read, then advances the position; temperature reads walk bits 0..8 and configuration reads bits 0..7.
- R10: When the position reaches 9 for a temperature read or 8 for a configuration read, the shifters clear, so further reads return 0 until a new command.
- R11: A read of address 2 with no held read command (none, incomplete or unknown) returns 0 and leaves the position unchanged.
- R12: A side-port load writes `pre_value` into the temperature value (`pre_cfg`=0) or the low 8 bits into the configuration value (`pre_cfg`=1) of lane `pre_lane`; a read in the same cycle still returns the value held before the load.
- R13: When `bus_rd` and `bus_wr` are both high the write is dropped; a read of an address other than 2 returns 0 and moves nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 4 | Read data, one bit per lane, registered |
| cmd_unknown | output | 1 | One-cycle pulse after an unrecognised command completes |
| pre_we | input | 1 | Side-port load strobe |
| pre_cfg | input | 1 | Side-port target: 1 configuration, 0 temperature |
| pre_lane | input | 2 | Side-port lane index |
| pre_value | input | 9 | Side-port load value |

## Verification
Two pairs of functions can meet in one cycle: a side-port load can land on the lane being read, and a host read can coincide with a host write. The bench raises both strobes together in a single cycle, in one case loading the lane bits that the read is about to deliver and in the other writing a reset or rewind code during a read. The reference model applies the read against the values held before the edge and drops the write, and the per-cycle comparison of `bus_rdata` over the following reads shows whether the design ordered the two the same way.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

    // Default geometry
    localparam int unsigned LANES     = 4;
    localparam int unsigned CMD_BITS  = 8;
    localparam int unsigned TEMP_BITS = 9;
    localparam int unsigned CFG_BITS  = 8;
    localparam int unsigned DATA_BITS = 16;

    // Register addresses
    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_WR  = 2'd1;
    localparam logic [1:0] ADDR_RD  = 2'd2;

    // Control register codes
    localparam logic [7:0] CTL_CLEAR    = 8'h01;
    localparam logic [7:0] CTL_SCK_LOW  = 8'h02;
    localparam logic [7:0] CTL_SCK_HIGH = 8'h03;

    // Data-write register codes
    localparam logic [7:0] WR_ONE    = 8'h01;
    localparam logic [7:0] WR_REWIND = 8'h04;

    // Command opcodes
    localparam logic [7:0] OP_GET_TEMP = 8'hAA;
    localparam logic [7:0] OP_GET_CFG  = 8'hAC;
    localparam logic [7:0] OP_CONVERT  = 8'hEE;

    // Lane values after reset
    localparam logic [8:0] TEMP_RESET = 9'd44;
    localparam logic [7:0] CFG_RESET  = 8'h02;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TEMP = 2'd1,
        SRC_CFG  = 2'd2
    } rd_src_e;

endpackage

// File: rtl/thermo_lane.sv
module thermo_lane
    import thermo_pkg::*;
#(
    parameter int unsigned TEMP_BITS = thermo_pkg::TEMP_BITS,
    parameter int unsigned CFG_BITS  = thermo_pkg::CFG_BITS,
    parameter int unsigned POS_W     = 5,
    parameter logic [TEMP_BITS-1:0] TEMP_INIT = TEMP_BITS'(thermo_pkg::TEMP_RESET),
    parameter logic [CFG_BITS-1:0]  CFG_INIT  = CFG_BITS'(thermo_pkg::CFG_RESET)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pre_hit,
    input  logic                 pre_cfg,
    input  logic [TEMP_BITS-1:0] pre_value,
    input  logic [POS_W-1:0]     pos,
    input  rd_src_e              src,
    output logic                 bit_o
);

    typedef struct packed {
        logic [TEMP_BITS-1:0] temp;
        logic [CFG_BITS-1:0]  cfg;
    } lane_t;

    lane_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (pre_hit) begin
            if (pre_cfg) nxt_d.cfg  = pre_value[CFG_BITS-1:0];
            else         nxt_d.temp = pre_value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.temp <= TEMP_INIT;
            cur_q.cfg  <= CFG_INIT;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // Bit at the shared position; a position past the value's width reads as 0
    logic temp_bit, cfg_bit;
    always_comb begin
        temp_bit = |(cur_q.temp & (TEMP_BITS'(1) << pos));
        cfg_bit  = |(cur_q.cfg  & (CFG_BITS'(1)  << pos));
        case (src)
            SRC_TEMP: bit_o = temp_bit;
            SRC_CFG:  bit_o = cfg_bit;
            default:  bit_o = 1'b0;
        endcase
    end

    AST_PRELOAD_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && !pre_cfg) |=> (cur_q.temp == $past(pre_value))); // R12
    AST_PRELOAD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && pre_cfg) |=> (cur_q.cfg == $past(pre_value[CFG_BITS-1:0]))); // R12
    AST_NO_LOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_hit |=> $stable(cur_q)); // R12

endmodule

// File: rtl/thermo_shifter.sv
module thermo_shifter
    import thermo_pkg::*;
#(
    parameter int unsigned CMD_BITS  = thermo_pkg::CMD_BITS,
    parameter int unsigned TEMP_BITS = thermo_pkg::TEMP_BITS,
    parameter int unsigned CFG_BITS  = thermo_pkg::CFG_BITS,
    parameter int unsigned DATA_BITS = thermo_pkg::DATA_BITS,
    parameter int unsigned POS_W     = $clog2(DATA_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             dat_wr,
    input  logic             rd_go,
    input  logic [7:0]       wbyte,
    output logic [POS_W-1:0] pos_o,
    output rd_src_e          src_o,
    output logic             unknown_o
);

    localparam int unsigned CPOS_W = $clog2(CMD_BITS + 1);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    typedef struct packed {
        logic [CMD_BITS-1:0]  cmd;
        logic [CPOS_W-1:0]    cpos;
        logic [DATA_BITS-1:0] data;
        logic [POS_W-1:0]     dpos;
        logic                 sck_low;
        logic                 unk;
    } sh_t;

    sh_t cur_q, nxt_d;

    function automatic sh_t wipe(input sh_t s);
        sh_t r;
        r      = s;
        r.cmd  = '0;
        r.cpos = '0;
        r.data = '0;
        r.dpos = '0;
        return r;
    endfunction

    // Decode of the held command
    logic    cmd_full;
    rd_src_e src;
    always_comb begin
        cmd_full = (cur_q.cpos == CPOS_W'(CMD_BITS));
        src      = SRC_NONE;
        if (cmd_full && cur_q.cmd == CMD_BITS'(OP_GET_TEMP))     src = SRC_TEMP;
        else if (cmd_full && cur_q.cmd == CMD_BITS'(OP_GET_CFG)) src = SRC_CFG;
    end

    // Helpers shared by the read and write paths
    logic [POS_W-1:0]    pos_inc;
    logic [POS_W-1:0]    rd_limit;
    logic                bit_one;
    logic [CMD_BITS-1:0] cmd_next;
    always_comb begin
        pos_inc  = (cur_q.dpos == POS_MAX) ? cur_q.dpos : cur_q.dpos + 1'b1;
        rd_limit = (src == SRC_TEMP) ? POS_W'(TEMP_BITS) : POS_W'(CFG_BITS);
        bit_one  = (wbyte == WR_ONE);
        cmd_next = cur_q.cmd | (CMD_BITS'(bit_one) << cur_q.cpos);
    end

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.unk = 1'b0;
        if (rd_go) begin
            if (src != SRC_NONE) begin
                nxt_d.dpos = pos_inc;
                if (pos_inc >= rd_limit) nxt_d = wipe(nxt_d);
            end
        end else if (ctl_wr) begin
            case (wbyte)
                CTL_CLEAR:    nxt_d = wipe(nxt_d);
                CTL_SCK_LOW:  nxt_d.sck_low = 1'b1;
                CTL_SCK_HIGH: nxt_d.sck_low = 1'b0;
                default:      ;
            endcase
        end else if (dat_wr) begin
            if (wbyte == WR_REWIND) begin
                nxt_d.dpos = '0;
            end else if (cur_q.sck_low) begin
                if (!cmd_full) begin
                    nxt_d.cmd  = cmd_next;
                    nxt_d.cpos = cur_q.cpos + 1'b1;
                    if (cur_q.cpos == CPOS_W'(CMD_BITS - 1)) begin
                        if (cmd_next == CMD_BITS'(OP_CONVERT)) begin
                            nxt_d = wipe(nxt_d);
                        end else if (cmd_next != CMD_BITS'(OP_GET_TEMP) &&
                                     cmd_next != CMD_BITS'(OP_GET_CFG)) begin
                            nxt_d.unk = 1'b1;
                        end
                    end
                end else begin
                    nxt_d.data = cur_q.data | (DATA_BITS'(bit_one) << cur_q.dpos);
                    nxt_d.dpos = pos_inc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pos_o     = cur_q.dpos;
    assign src_o     = src;
    assign unknown_o = cur_q.unk;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wbyte == CTL_CLEAR) |=> (cur_q.cpos == '0 && cur_q.dpos == '0 && cur_q.cmd == '0)); // R3
    AST_IDLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && wbyte != WR_REWIND && !cur_q.sck_low) |=> ($stable(cur_q.cpos) && $stable(cur_q.dpos))); // R4
    AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && wbyte == WR_REWIND) |=> (cur_q.dpos == '0 && $stable(cur_q.cpos))); // R5
    AST_CMD_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cpos <= CPOS_W'(CMD_BITS)); // R6
    AST_UNKNOWN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        unknown_o |=> !unknown_o); // R7
    AST_IDLE_READ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && src == SRC_NONE) |=> $stable(cur_q.dpos)); // R11

endmodule

// File: rtl/thermo_bridge.sv
module thermo_bridge
    import thermo_pkg::*;
#(
    parameter int unsigned NUM_LANES = thermo_pkg::LANES,
    parameter int unsigned CMD_BITS  = thermo_pkg::CMD_BITS,
    parameter int unsigned TEMP_BITS = thermo_pkg::TEMP_BITS,
    parameter int unsigned CFG_BITS  = thermo_pkg::CFG_BITS,
    parameter int unsigned DATA_BITS = thermo_pkg::DATA_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [1:0]                   bus_addr,
    input  logic [7:0]                   bus_wdata,
    output logic [NUM_LANES-1:0]         bus_rdata,
    output logic                         cmd_unknown,
    input  logic                         pre_we,
    input  logic                         pre_cfg,
    input  logic [$clog2(NUM_LANES)-1:0] pre_lane,
    input  logic [TEMP_BITS-1:0]         pre_value
);

    localparam int unsigned LANE_W = $clog2(NUM_LANES);
    localparam int unsigned POS_W  = $clog2(DATA_BITS + 1);

    // Host decode: a read in the same cycle wins over a write
    logic ctl_wr, dat_wr, rd_go;
    always_comb begin
        ctl_wr = bus_wr && !bus_rd && (bus_addr == ADDR_CTL);
        dat_wr = bus_wr && !bus_rd && (bus_addr == ADDR_WR);
        rd_go  = bus_rd && (bus_addr == ADDR_RD);
    end

    logic [POS_W-1:0]     shared_pos;
    rd_src_e              src;
    logic [NUM_LANES-1:0] lane_bits;

    thermo_shifter #(
        .CMD_BITS  (CMD_BITS),
        .TEMP_BITS (TEMP_BITS),
        .CFG_BITS  (CFG_BITS),
        .DATA_BITS (DATA_BITS),
        .POS_W     (POS_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .dat_wr    (dat_wr),
        .rd_go     (rd_go),
        .wbyte     (bus_wdata),
        .pos_o     (shared_pos),
        .src_o     (src),
        .unknown_o (cmd_unknown)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        thermo_lane #(
            .TEMP_BITS (TEMP_BITS),
            .CFG_BITS  (CFG_BITS),
            .POS_W     (POS_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .pre_hit   (pre_we && (pre_lane == LANE_W'(g))),
            .pre_cfg   (pre_cfg),
            .pre_value (pre_value),
            .pos       (shared_pos),
            .src       (src),
            .bit_o     (lane_bits[g])
        );
    end

    // Registered read data, held between reads
    logic [NUM_LANES-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd) rdata_d = rd_go ? lane_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && src == SRC_NONE) |=> (bus_rdata == '0)); // R11
    AST_OFF_READ_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != ADDR_RD) |=> ($stable(shared_pos) && bus_rdata == '0)); // R13
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R9

endmodule

// File: tb/thermo_bridge_tb.sv
`timescale 1ns/100ps
module thermo_bridge_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [3:0] bus_rdata;
    logic       cmd_unknown;
    logic       pre_we = 1'b0;
    logic       pre_cfg = 1'b0;
    logic [1:0] pre_lane = 2'd0;
    logic [8:0] pre_value = 9'd0;

    always #2.5 clk = ~clk;   // 200 MHz

    thermo_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_unknown(cmd_unknown), .pre_we(pre_we), .pre_cfg(pre_cfg),
        .pre_lane(pre_lane), .pre_value(pre_value)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // Behavioural reference model
    int m_cmd, m_cpos, m_data, m_dpos, m_low;
    int m_temp[4];
    int m_cfg[4];
    logic [3:0] e_rd;
    logic       e_unk;

    task automatic model_init();
        m_cmd = 0; m_cpos = 0; m_data = 0; m_dpos = 0; m_low = 0;
        for (int i = 0; i < 4; i++) begin m_temp[i] = 44; m_cfg[i] = 2; end
        e_rd = '0; e_unk = 1'b0;
    endtask

    task automatic model_clear();
        m_cmd = 0; m_cpos = 0; m_data = 0; m_dpos = 0;
    endtask

    task automatic model_step();
        int lim;
        int kind;
        e_unk = 1'b0;
        if (bus_rd) begin
            if (bus_addr == 2'd2) begin
                kind = 0; lim = 0;
                if (m_cpos == 8 && m_cmd == 'hAA) begin kind = 1; lim = 9; end
                else if (m_cpos == 8 && m_cmd == 'hAC) begin kind = 2; lim = 8; end
                if (kind == 0) e_rd = '0;
                else begin
                    for (int i = 0; i < 4; i++) begin
                        int v;
                        v = (kind == 1) ? m_temp[i] : m_cfg[i];
                        e_rd[i] = (m_dpos < lim) ? ((v >> m_dpos) & 1) : 1'b0;
                    end
                    if (m_dpos < 31) m_dpos++;
                    if (m_dpos >= lim) model_clear();
                end
            end else e_rd = '0;
        end else if (bus_wr) begin
            if (bus_addr == 2'd0) begin
                if (bus_wdata == 8'h01) model_clear();
                else if (bus_wdata == 8'h02) m_low = 1;
                else if (bus_wdata == 8'h03) m_low = 0;
            end else if (bus_addr == 2'd1) begin
                if (bus_wdata == 8'h04) m_dpos = 0;
                else if (m_low != 0) begin
                    if (m_cpos < 8) begin
                        if (bus_wdata == 8'h01) m_cmd = m_cmd | (1 << m_cpos);
                        m_cpos++;
                        if (m_cpos == 8) begin
                            if (m_cmd == 'hEE) model_clear();
                            else if (m_cmd != 'hAA && m_cmd != 'hAC) e_unk = 1'b1;
                        end
                    end else begin
                        if (bus_wdata == 8'h01 && m_dpos < 16) m_data = m_data | (1 << m_dpos);
                        if (m_dpos < 31) m_dpos++;
                    end
                end
            end
        end
        if (pre_we) begin
            if (pre_cfg) m_cfg[pre_lane] = pre_value & 'hFF;
            else         m_temp[pre_lane] = pre_value;
        end
    endtask

    task automatic compare();
        checks++;
        if (bus_rdata !== e_rd) begin
            errors++;
            $display("FAIL %s bus_rdata actual=%b expected=%b", cur_req, bus_rdata, e_rd);
        end
        checks++;
        if (cmd_unknown !== e_unk) begin
            errors++;
            $display("FAIL %s cmd_unknown actual=%b expected=%b", cur_req, cmd_unknown, e_unk);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        compare();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a = 2'd2);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic preload(input int lane, input logic cfg, input int val);
        pre_we = 1'b1; pre_lane = 2'(lane); pre_cfg = cfg; pre_value = 9'(val);
        tick();
        pre_we = 1'b0;
    endtask

    // Clock toggled around every bit as a host would do
    task automatic send_cmd(input logic [7:0] op);
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, 8'h03);
            wr(2'd0, 8'h02);
            wr(2'd1, op[i] ? 8'h01 : 8'h00);
        end
    endtask

    task automatic reads(input int n);
        for (int i = 0; i < n; i++) rd();
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL %s watchdog actual=timeout expected=finished", cur_req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_init();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        cur_req = "R1";
        compare();

        // R11: read with nothing held
        cur_req = "R11";
        reads(2);

        // R1, R6, R9, R10: read-temp over default values, then auto-reset
        cur_req = "R9";
        send_cmd(8'hAA);
        reads(9);
        cur_req = "R10";
        reads(2);

        // R6: read-config command, LSB-first
        cur_req = "R6";
        send_cmd(8'hAC);
        reads(8);
        cur_req = "R10";
        rd();

        // R12: side-port loads, distinct per lane
        cur_req = "R12";
        preload(0, 1'b0, 'h1FF);
        preload(1, 1'b0, 'h155);
        preload(2, 1'b0, 'h0AA);
        preload(3, 1'b0, 'h001);
        preload(0, 1'b1, 'h5A);
        preload(1, 1'b1, 'hC3);
        preload(2, 1'b1, 'h0F);
        preload(3, 1'b1, 'hF0);
        send_cmd(8'hAA);
        reads(9);
        send_cmd(8'hAC);
        reads(8);

        // R12: load and read in the same cycle
        send_cmd(8'hAA);
        rd();
        bus_rd = 1'b1; bus_addr = 2'd2;
        pre_we = 1'b1; pre_lane = 2'd1; pre_cfg = 1'b0; pre_value = 9'h0AA;
        tick();
        bus_rd = 1'b0; pre_we = 1'b0;
        reads(7);

        // R5: rewind mid-read, also with clock-low clear
        cur_req = "R5";
        send_cmd(8'hAA);
        reads(3);
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h04);
        reads(9);

        // R4: writes ignored while clock-low is clear
        cur_req = "R4";
        wr(2'd0, 8'h03);
        for (int i = 0; i < 5; i++) wr(2'd1, 8'h01);
        send_cmd(8'hAA);
        reads(9);

        // R3: partial command cleared by reset code, clock-low kept
        cur_req = "R3";
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h01);
        send_cmd(8'hAC);
        reads(8);

        // R2: unrecognised control value has no effect
        cur_req = "R2";
        wr(2'd0, 8'h02);
        wr(2'd0, 8'h07);
        send_cmd(8'hAC);
        reads(4);
        rd(2'd0);
        reads(4);

        // R7: start-convert clears, unknown pulses
        cur_req = "R7";
        send_cmd(8'hEE);
        reads(2);
        send_cmd(8'h55);
        tick();
        reads(2);
        wr(2'd0, 8'h01);

        // R8: data writes after the command shift data and move the position
        cur_req = "R8";
        send_cmd(8'hAA);
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h00);
        reads(8);
        send_cmd(8'hAC);
        for (int i = 0; i < 12; i++) wr(2'd1, 8'h01);
        reads(2);

        // R13: read and write in the same cycle, write dropped
        cur_req = "R13";
        send_cmd(8'hAA);
        rd();
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h01;
        tick();
        bus_rd = 1'b0; bus_wr = 1'b0;
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h04;
        tick();
        bus_rd = 1'b0; bus_wr = 1'b0;
        reads(8);

        repeat (2) tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule